// File: doc/BRIEF.md
# In-Group Store-Load Overlap Detector

The detector keeps a small table of the stores issued since the last dispatch-group boundary. It checks every load presented afterwards in the same group against each stored entry. A load that may read bytes written by a recorded store raises a no-op hazard, so the issue logic can pad the group with a no-op instead of risking a replay.

Each access has a size code and two address operands. The first operand is an offset, and the second is a base. Each operand is either a register identifier or a constant, and a flag tells which. The comparison reports a conflict in three cases:
- the operand pairs are identical;
- the operand pairs are identical after swapping;
- the bases agree, both offsets are constants, and the two byte ranges intersect.

A group-end pulse empties the table.

Top module: `ld_st_overlap_det`

## Requirements
- R1: After reset, and after any clock edge with `grp_end` high and `st_vld` low, the table is empty, and a load presented in the following cycle raises no hazard.
- R2: A size code c in 0..4 means 2^c bytes. Codes 5 to 7 mean 16 bytes. This applies to both loads and stores.
- R3: Two operands are equal only when their constant flags agree and their values agree. A load whose first and second operands equal a recorded store's first and second operands raises `noop_hazard`.
- R4: A load whose first operand equals a store's second operand, and whose second operand equals that store's first operand, raises `noop_hazard`.
- R5: Take a recorded store at constant offset S with size SB and a load at constant offset L with size LB, with equal second operands. There is a hazard when S < L and S+SB > L, or when S >= L and L+LB > S. Sums are formed one bit wider than the offset, so they cannot wrap.
- R6: `noop_hazard` is high only while `ld_vld` is high and at least one store is recorded. It is combinational in the load inputs and the table.
- R7: The table holds DEPTH entries (default 5). A store presented while the table is full and `grp_end` is low is dropped. In that same cycle, `st_overflow` is high.
- R8: A store is recorded at the clock edge that ends its cycle. A load presented in the same cycle as the store does not see it, and a load in any later cycle of the group does.
- R9: When `grp_end` and `st_vld` are high together, the store becomes the only entry of the new group. A load in that cycle is still checked against the old entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_end | input | 1 | Dispatch-group boundary; empties the table at the edge |
| st_vld | input | 1 | A store is issued this cycle |
| st_size | input | 3 | Store size code (R2) |
| st_a_const | input | 1 | Store first operand is a constant |
| st_a | input | OFS_W | Store first operand value or identifier |
| st_b_const | input | 1 | Store second operand is a constant |
| st_b | input | OFS_W | Store second operand value or identifier |
| ld_vld | input | 1 | A load is being checked this cycle |
| ld_size | input | 3 | Load size code (R2) |
| ld_a_const | input | 1 | Load first operand is a constant |
| ld_a | input | OFS_W | Load first operand value or identifier |
| ld_b_const | input | 1 | Load second operand is a constant |
| ld_b | input | OFS_W | Load second operand value or identifier |
| noop_hazard | output | 1 | Load conflicts with a recorded store |
| st_overflow | output | 1 | Store dropped because the table is full |

## Verification
The bench builds the detector with DEPTH=5 and OFS_W=4. The narrow offset allows a full sweep of every store offset, store size code, load offset and load size code against one shared base register: 16,384 pairs. Each pair is compared with a plain interval-intersection formula. Every range boundary, the wider-sum case and the three oversize codes are therefore covered. With a depth of five, the full-table drop, the visibility of the last slot and the simultaneous clear-and-record case are reached in a few cycles.

// File: rtl/ld_st_overlap_det.sv
module ld_st_overlap_det #(
  parameter int DEPTH = 5,
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_end,
  input  logic             st_vld,
  input  logic [2:0]       st_size,
  input  logic             st_a_const,
  input  logic [OFS_W-1:0] st_a,
  input  logic             st_b_const,
  input  logic [OFS_W-1:0] st_b,
  input  logic             ld_vld,
  input  logic [2:0]       ld_size,
  input  logic             ld_a_const,
  input  logic [OFS_W-1:0] ld_a,
  input  logic             ld_b_const,
  input  logic [OFS_W-1:0] ld_b,
  output logic             noop_hazard,
  output logic             st_overflow
);
  localparam int OP_W  = OFS_W + 1;
  localparam int SUM_W = OFS_W + 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  function automatic logic [SUM_W-1:0] nbytes(input logic [2:0] code);
    nbytes = (code > 3'd4) ? SUM_W'(16) : SUM_W'(1) << code;
  endfunction

  logic [OP_W-1:0] t_a  [DEPTH];
  logic [OP_W-1:0] t_b  [DEPTH];
  logic [2:0]      t_sz [DEPTH];
  logic [CNT_W-1:0] fill;
  logic [DEPTH-1:0] hit;

  wire full = (fill == CNT_W'(DEPTH));
  wire wr_en = st_vld && (grp_end || !full);
  wire [CNT_W-1:0] wr_idx = grp_end ? '0 : fill;
  wire [OP_W-1:0] la = {ld_a_const, ld_a};
  wire [OP_W-1:0] lb = {ld_b_const, ld_b};
  wire [SUM_W-1:0] l_end = {1'b0, ld_a} + nbytes(ld_size);

  assign st_overflow = st_vld && !grp_end && full;
  assign noop_hazard = ld_vld && (|hit);

  always_ff @(posedge clk) begin
    if (!rst_n) fill <= '0;
    else if (grp_end) fill <= st_vld ? CNT_W'(1) : '0;
    else if (wr_en) fill <= fill + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      t_a[wr_idx]  <= {st_a_const, st_a};
      t_b[wr_idx]  <= {st_b_const, st_b};
      t_sz[wr_idx] <= st_size;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    wire live = CNT_W'(i) < fill;
    wire exact = (la == t_a[i]) && (lb == t_b[i]);
    wire swap  = (la == t_b[i]) && (lb == t_a[i]);
    wire [OFS_W-1:0] s_off = t_a[i][OFS_W-1:0];
    wire [SUM_W-1:0] s_end = {1'b0, s_off} + nbytes(t_sz[i]);
    wire consts = t_a[i][OFS_W] && ld_a_const && (lb == t_b[i]);
    wire ovl = (s_off < ld_a) ? (s_end > {1'b0, ld_a}) : (l_end > {1'b0, s_off});
    assign hit[i] = live && (exact || swap || (consts && ovl));
  end
endmodule

module ld_st_overlap_det_chk #(
  parameter int DEPTH = 5,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             grp_end,
  input logic             st_vld,
  input logic             ld_vld,
  input logic             noop_hazard,
  input logic             st_overflow,
  input logic [CNT_W-1:0] fill
);
  // R6
  hazard_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    noop_hazard |-> ld_vld);
  // R6
  hazard_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    noop_hazard |-> fill != '0);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_overflow |-> st_vld && fill == CNT_W'(DEPTH));
  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));
  // R1
  clear_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_end && !st_vld |=> fill == '0);
  // R9
  end_with_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_end && st_vld |=> fill == CNT_W'(1));
endmodule

bind ld_st_overlap_det ld_st_overlap_det_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_end(grp_end), .st_vld(st_vld), .ld_vld(ld_vld),
  .noop_hazard(noop_hazard), .st_overflow(st_overflow), .fill(fill)
);

// File: tb/ld_st_overlap_det_bench.sv
module ld_st_overlap_det_bench;
  localparam int W = 4;
  logic clk = 0, rst_n = 0, grp_end = 0, st_vld = 0, ld_vld = 0;
  logic [2:0] st_size = 0, ld_size = 0;
  logic st_a_const = 0, st_b_const = 0, ld_a_const = 0, ld_b_const = 0;
  logic [W-1:0] st_a = 0, st_b = 0, ld_a = 0, ld_b = 0;
  logic noop_hazard, st_overflow;
  int n_run = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ld_st_overlap_det #(.DEPTH(5), .OFS_W(W)) u_ld_st_overlap_det (.*);

  task automatic chk(input string req, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic idle();
    grp_end = 0; st_vld = 0; ld_vld = 0;
  endtask

  task automatic set_st(input logic [2:0] sz, input logic ac, input int a, input logic bc, input int b);
    st_vld = 1; st_size = sz; st_a_const = ac; st_a = W'(a); st_b_const = bc; st_b = W'(b);
  endtask

  task automatic set_ld(input logic [2:0] sz, input logic ac, input int a, input logic bc, input int b);
    ld_vld = 1; ld_size = sz; ld_a_const = ac; ld_a = W'(a); ld_b_const = bc; ld_b = W'(b);
  endtask

  task automatic clear();
    @(negedge clk); idle(); grp_end = 1;
    @(negedge clk); idle();
  endtask

  task automatic store(input logic [2:0] sz, input logic ac, input int a, input logic bc, input int b);
    @(negedge clk); idle(); set_st(sz, ac, a, bc, b);
    @(negedge clk); idle();
  endtask

  task automatic probe(input string req, input logic [2:0] sz, input logic ac, input int a,
                       input logic bc, input int b, input logic exp);
    idle(); set_ld(sz, ac, a, bc, b); #1;
    chk(req, noop_hazard, exp);
    idle();
  endtask

  function automatic int nb(input int c);
    return (c > 4) ? 16 : (1 << c);
  endfunction

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 200000 && !done) begin
        done = 1; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset overflow", st_overflow, 0);
    probe("R1 reset load", 3'd2, 1, 2, 0, 3, 0);

    // R3 exact, identifier and constant-flag sensitivity
    clear(); store(3'd2, 0, 5, 0, 9);
    probe("R3 exact", 3'd2, 0, 5, 0, 9, 1);
    probe("R3 base differs", 3'd2, 0, 5, 0, 8, 0);
    probe("R3 const flag differs", 3'd2, 1, 5, 0, 9, 0);
    // R4 swapped pair
    probe("R4 swapped", 3'd2, 0, 9, 0, 5, 1);
    // R6 no load, no hazard
    idle(); #1; chk("R6 idle", noop_hazard, 0);
    // R1 cleared after group end
    clear();
    probe("R1 after clear", 3'd2, 0, 5, 0, 9, 0);

    // R5 different base with constant offsets
    store(3'd3, 1, 2, 0, 3);
    probe("R5 other base", 3'd3, 1, 2, 0, 4, 0);

    // R2 oversize codes: store code 7 at 0 covers 15; code 3 does not
    clear(); store(3'd7, 1, 0, 0, 3);
    probe("R2 code7", 3'd0, 1, 15, 0, 3, 1);
    clear(); store(3'd3, 1, 0, 0, 3);
    probe("R2 code3", 3'd0, 1, 15, 0, 3, 0);

    // R7 full table and overflow
    clear();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); idle(); set_st(3'd2, 0, k, 0, 10 + k); #1;
      chk("R7 not full", st_overflow, 0);
    end
    @(negedge clk); idle(); set_st(3'd2, 0, 7, 0, 15); #1;
    chk("R7 overflow", st_overflow, 1);
    @(negedge clk);
    probe("R7 last slot", 3'd2, 0, 4, 0, 14, 1);
    probe("R7 dropped", 3'd2, 0, 7, 0, 15, 0);

    // R8 same-cycle store invisible
    clear();
    @(negedge clk); idle(); set_st(3'd2, 0, 1, 0, 2); set_ld(3'd2, 0, 1, 0, 2); #1;
    chk("R8 same cycle", noop_hazard, 0);
    @(negedge clk); st_vld = 0; #1;
    chk("R8 next cycle", noop_hazard, 1);

    // R9 group end with store
    @(negedge clk); idle(); grp_end = 1; set_st(3'd2, 0, 6, 0, 7); set_ld(3'd2, 0, 1, 0, 2); #1;
    chk("R9 old entries", noop_hazard, 1);
    chk("R9 no overflow", st_overflow, 0);
    @(negedge clk);
    probe("R9 old gone", 3'd2, 0, 1, 0, 2, 0);
    probe("R9 new entry", 3'd2, 0, 6, 0, 7, 1);

    // R5 R2 sweep of constant-offset ranges on one base
    for (int sc = 0; sc < 8; sc++)
      for (int so = 0; so < 16; so++)
        for (int lc = 0; lc < 8; lc++)
          for (int lo = 0; lo < 16; lo++) begin
            clear(); store(3'(sc), 1, so, 0, 3);
            probe("R5 sweep", 3'(lc), 1, lo, 0, 3,
                  (so < lo + nb(lc)) && (lo < so + nb(sc)));
          end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule